// File: doc/BRIEF.md
# Binary Coded Ternary Latch Register

This block holds a word of balanced-ternary digits, each digit carried on two binary wires. A trit is never stored in a single three-level cell. Each trit is kept in two independent binary flip-flops, one for the negative half of the code and one for the positive half. Both halves are sampled on a system clock. The word width is set in trits by a parameter, with a default of six.

Two control inputs decide what the register does on each clock edge, and both are trits:
- The enable trit is read as a level. At +1 the register follows its data input. At -1 it keeps its contents. An enable of 0, which can appear for a moment while the enable swings from -1 to +1, also keeps the contents. So a swing through 0 can never load a value that was not presented under +1.
- The reset trit clears the whole word to 0 when it is -1, and it overrides the enable.

A data trit carrying the unused code is stored as 0, and a flag reports it.

Top module: `bct_latch_reg`

## Requirements
- R1: Every output trit always carries one of the three legal codes: 10 for -1, 00 for 0, 01 for +1. The code 11 never appears at the output.
- R2: When the reset trit is 10 (-1) at a rising clock edge, every stored trit becomes 00 and the error flag becomes 0, both visible after that edge.
- R3: Reset has priority. A reset trit of 10 clears the word even when the enable trit is 01 (+1) in the same cycle.
- R4: With the reset trit not 10 and the enable trit 01 (+1), the register takes the data input at the clock edge and shows it on the output after that edge.
- R5: With the enable trit 10 (-1), the stored word and the error flag do not change, whatever the data input does.
- R6: With the enable trit 00 (0), the stored word and the error flag do not change.
- R7: With the enable trit at the unused code 11, the stored word and the error flag do not change.
- R8: On a load, an input trit of 11 is stored as 00. The other trits in the same word are stored unchanged.
- R9: After each load, the error flag is 1 when at least one input trit was 11 and 0 otherwise. It keeps its value while the register holds.
- R10: A reset trit of 00 or 01 or 11 does not clear the register.
- R11: An enable sequence of -1, then 0, then +1 leaves the old contents in place until the +1 edge. At the +1 edge the register stores exactly the word presented at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. All storage is updated on its rising edge. |
| din | input | 2*TRITS | Data word. Trit i sits at bits [2i+1:2i] as {negative, positive}. |
| en_trit | input | 2 | Enable trit. 01 means follow; 10, 00 and 11 mean hold. |
| rst_trit | input | 2 | Reset trit. 10 clears the word; any other code has no effect. |
| dout | output | 2*TRITS | Stored word, using the same layout as din. |
| code_err | output | 1 | Set when the last loaded word contained the code 11. |

## Verification
The assertions check the following on every cycle once the first reset has happened:
- the output never carries 11;
- a reset cycle leaves the word at zero;
- a follow cycle stores the cleaned input and sets the flag to match it;
- every other enable code leaves both the word and the flag unchanged.

Some behaviours span several cycles, and only the bench scenarios show them. These are the -1, 0, +1 enable swing, the error flag clearing on a later clean load, and reset taking priority over a simultaneous load.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_NEG  = 2'b10;
  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_POS  = 2'b01;
  localparam trit_t TRIT_BAD  = 2'b11;

  // True when a trit carries the unused code.
  function automatic logic trit_is_bad(input trit_t t);
    return t == TRIT_BAD;
  endfunction

  // Maps the unused code onto zero and leaves legal codes alone.
  function automatic trit_t trit_clean(input trit_t t);
    return trit_is_bad(t) ? TRIT_ZERO : t;
  endfunction
endpackage

// File: rtl/bct_ctrl_decode.sv
module bct_ctrl_decode
  import bct_pkg::*;
(
  input  trit_t en_trit,
  input  trit_t rst_trit,
  output logic  do_clear,
  output logic  do_load
);
  // Only +1 on the enable follows; -1, 0 and 11 all hold.
  always_comb begin
    do_clear = (rst_trit == TRIT_NEG);
    do_load  = !do_clear && (en_trit == TRIT_POS);
  end
endmodule

// File: rtl/bct_trit_cell.sv
module bct_trit_cell
  import bct_pkg::*;
(
  input  logic  clk,
  input  logic  do_clear,
  input  logic  do_load,
  input  trit_t d,
  output trit_t q
);
  trit_t d_clean;
  logic  bit_neg;
  logic  bit_pos;

  assign d_clean = trit_clean(d);

  // Two separate binary flip-flops hold the two halves of the code.
  always_ff @(posedge clk) begin
    if (do_clear)     bit_neg <= 1'b0;
    else if (do_load) bit_neg <= d_clean[1];
  end

  always_ff @(posedge clk) begin
    if (do_clear)     bit_pos <= 1'b0;
    else if (do_load) bit_pos <= d_clean[0];
  end

  assign q = {bit_neg, bit_pos};
endmodule

// File: rtl/bct_err_flag.sv
module bct_err_flag (
  input  logic clk,
  input  logic do_clear,
  input  logic do_load,
  input  logic any_bad,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (do_clear)     flag <= 1'b0;
    else if (do_load) flag <= any_bad;
  end
endmodule

// File: rtl/bct_latch_reg.sv
module bct_latch_reg
  import bct_pkg::*;
#(
  parameter int TRITS = 6
) (
  input  logic               clk,
  input  logic [2*TRITS-1:0] din,
  input  logic [1:0]         en_trit,
  input  logic [1:0]         rst_trit,
  output logic [2*TRITS-1:0] dout,
  output logic               code_err
);
  localparam int WBITS = 2 * TRITS;

  logic             do_clear;
  logic             do_load;
  logic [TRITS-1:0] bad_in;
  logic [WBITS-1:0] store_q;

  bct_ctrl_decode u_ctrl (
    .en_trit  (en_trit),
    .rst_trit (rst_trit),
    .do_clear (do_clear),
    .do_load  (do_load)
  );

  for (genvar i = 0; i < TRITS; i++) begin : g_trit
    assign bad_in[i] = trit_is_bad(din[2*i +: 2]);

    bct_trit_cell u_cell (
      .clk      (clk),
      .do_clear (do_clear),
      .do_load  (do_load),
      .d        (din[2*i +: 2]),
      .q        (store_q[2*i +: 2])
    );
  end

  bct_err_flag u_err (
    .clk      (clk),
    .do_clear (do_clear),
    .do_load  (do_load),
    .any_bad  (|bad_in),
    .flag     (code_err)
  );

  assign dout = store_q;
endmodule

// File: rtl/bct_latch_reg_chk.sv
module bct_latch_reg_chk #(
  parameter int TRITS = 6
) (
  input logic               clk,
  input logic [2*TRITS-1:0] din,
  input logic [1:0]         en_trit,
  input logic [1:0]         rst_trit,
  input logic [2*TRITS-1:0] dout,
  input logic               code_err
);
  logic armed = 1'b0;

  always_ff @(posedge clk)
    if (rst_trit == 2'b10) armed <= 1'b1;

  function automatic logic has_bad(input logic [2*TRITS-1:0] w);
    logic r = 1'b0;
    for (int i = 0; i < TRITS; i++) r |= (w[2*i +: 2] == 2'b11);
    return r;
  endfunction

  function automatic logic [2*TRITS-1:0] cleaned(input logic [2*TRITS-1:0] w);
    logic [2*TRITS-1:0] r = w;
    for (int i = 0; i < TRITS; i++)
      if (w[2*i +: 2] == 2'b11) r[2*i +: 2] = 2'b00;
    return r;
  endfunction

  AST_NO_BAD_OUT: assert property (@(posedge clk) disable iff (!armed)
    !has_bad(dout)); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!armed)
    rst_trit == 2'b10 |=> dout == '0 && !code_err); // R2

  AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!armed)
    rst_trit != 2'b10 && en_trit == 2'b01 |=> dout == cleaned($past(din))); // R8

  AST_ERR_TRACKS: assert property (@(posedge clk) disable iff (!armed)
    rst_trit != 2'b10 && en_trit == 2'b01 |=> code_err == $past(has_bad(din))); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!armed)
    rst_trit != 2'b10 && en_trit != 2'b01 |=> $stable(dout) && $stable(code_err)); // R6
endmodule

bind bct_latch_reg bct_latch_reg_chk #(.TRITS(TRITS)) u_chk (
  .clk      (clk),
  .din      (din),
  .en_trit  (en_trit),
  .rst_trit (rst_trit),
  .dout     (dout),
  .code_err (code_err)
);

// File: tb/bct_latch_reg_tb_top.sv
module bct_latch_reg_tb_top;
  localparam int TRITS = 6;
  localparam int W     = 2 * TRITS;
  localparam int NV    = 11;

  logic         clk = 1'b0;
  logic [W-1:0] din = '0;
  logic [1:0]   en_trit = 2'b00;
  logic [1:0]   rst_trit = 2'b00;
  logic [W-1:0] dout;
  logic         code_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bct_latch_reg #(.TRITS(TRITS)) dut_i (
    .clk      (clk),
    .din      (din),
    .en_trit  (en_trit),
    .rst_trit (rst_trit),
    .dout     (dout),
    .code_err (code_err)
  );

  // Each vector is {rst, en, din, expected dout, expected flag, requirement}.
  localparam logic [32:0] VEC [NV] = '{
    {2'b00, 2'b01, 12'h618, 12'h618, 1'b0, 4'd4},  // R4 load of mixed trits
    {2'b00, 2'b10, 12'hAAA, 12'h618, 1'b0, 4'd5},  // R5 hold at -1
    {2'b00, 2'b00, 12'h555, 12'h618, 1'b0, 4'd6},  // R6 hold at 0
    {2'b00, 2'b11, 12'h111, 12'h618, 1'b0, 4'd7},  // R7 hold at 11
    {2'b00, 2'b01, 12'h555, 12'h555, 1'b0, 4'd4},  // R4 load of all +1
    {2'b00, 2'b01, 12'h553, 12'h550, 1'b1, 4'd8},  // R8 one bad trit
    {2'b00, 2'b10, 12'h000, 12'h550, 1'b1, 4'd9},  // R9 flag held
    {2'b01, 2'b01, 12'hAAA, 12'hAAA, 1'b0, 4'd10}, // R10 reset +1 ignored
    {2'b11, 2'b10, 12'h000, 12'hAAA, 1'b0, 4'd10}, // R10 reset 11 ignored
    {2'b10, 2'b01, 12'h555, 12'h000, 1'b0, 4'd3},  // R3 reset beats load
    {2'b00, 2'b01, 12'hFFF, 12'h000, 1'b1, 4'd8}   // R8 all trits bad
  };

  function automatic bit out_legal(input logic [W-1:0] w);
    for (int i = 0; i < TRITS; i++)
      if (w[2*i +: 2] == 2'b11) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp_d, input logic exp_e);
    checks++;
    if (dout !== exp_d || code_err !== exp_e) begin
      errors++;
      $display("FAIL %s dout=%h err=%b expected dout=%h err=%b", req, dout, code_err, exp_d, exp_e);
    end
    checks++;
    if (!out_legal(dout)) begin
      errors++;
      $display("FAIL R1 dout=%h holds code 11, expected legal codes only", dout);
    end
  endtask

  // Drive on the falling edge; the result is read one full cycle later.
  task automatic step(input logic [1:0] r, input logic [1:0] e, input logic [W-1:0] d);
    rst_trit = r;
    en_trit  = e;
    din      = d;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step(2'b10, 2'b00, 12'h555);
    check("R2", 12'h000, 1'b0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][32:31], VEC[k][30:29], VEC[k][28:17]);
      check($sformatf("R%0d", VEC[k][3:0]), VEC[k][16:5], VEC[k][4]);
    end

    // R11: enable swings -1, 0, +1 with a different word on each cycle.
    step(2'b00, 2'b01, 12'h618);
    check("R11", 12'h618, 1'b0);
    step(2'b00, 2'b10, 12'h111);
    check("R11", 12'h618, 1'b0);
    step(2'b00, 2'b00, 12'hAAA);
    check("R11", 12'h618, 1'b0);
    step(2'b00, 2'b01, 12'h249);
    check("R11", 12'h249, 1'b0);

    // R2: reset clears a loaded word and a raised flag together.
    step(2'b00, 2'b01, 12'h61B);
    check("R9", 12'h618, 1'b1);
    step(2'b10, 2'b10, 12'h555);
    check("R2", 12'h000, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule